// File: doc/BRIEF.md
# Instruction Cache Prefetch Engine

This block produces line fill requests for an instruction cache before the processor needs them. It has two sources of requests. The first is autoload. It watches the stream of cache lookups, and when a lookup meets the selected trigger condition inside an enabled address window, it requests the neighbouring line. The second is a manual preload. It walks every line of one programmed range when software issues a command. Autoload is suspended while the walk runs and can be restored afterwards.

Configuration comes in through a small write port. Commands (suspend, resume, start walk, end walk) arrive on a separate operation port. Requests leave on a ready/valid channel that holds one line address. The tag and data arrays and the refill path sit outside this block.

Top module: `ipf_engine`

## Requirements
- R1: After reset, `fill_valid`, `auto_active` and `prev_auto` are 0 and `pre_done` is 1.
- R2: `line_sz` selects the line length: 0 gives 16 bytes, 1 gives 32 bytes, 2 gives 64 bytes, and 3 is treated as 64 bytes. Every `fill_addr` is aligned down to the line length.
- R3: The control word is written with `cfg_sel`=0. Bit 0 selects the step direction (0 for the next higher line, 1 for the next lower line). Bits 2:1 select the trigger (0 fires on a miss only, 1 on a hit only, 2 on either, 3 never). Bit 3 enables window 0, bit 4 enables window 1, and bit 5 turns autoload on. When autoload is active, no walk is running and no request is pending, a lookup that matches the trigger issues a request for the line one step away from the looked-up line, valid in the cycle after the lookup.
- R4: Window 0 has its base at `cfg_sel`=1 and its size at `cfg_sel`=2. Window 1 has its base at 3 and its size at 4. A lookup fires only if it lies in an enabled window, meaning base <= address < base+size. A lookup outside every enabled window gives no request.
- R5: Only one request is outstanding at a time. While `fill_valid` is high and `fill_ready` is low, the address is held, and lookups that arrive during that time are dropped.
- R6: The op code 1 (suspend) turns autoload off and loads `prev_auto` with its previous state. The op code 2 (resume) sets autoload to `op_flag`. While autoload is suspended, lookups give no request.
- R7: The op code 3 (start), accepted only when no walk is running, loads `prev_auto` with the autoload state and turns autoload off. With `op_desc`=0 it then requests every line from the line holding `op_addr` up to the line holding `op_addr+size-1`, one line per handshake.
- R8: With `op_desc`=1 the walk begins at the line holding `op_addr+size-1` and steps down to the line holding `op_addr`.
- R9: `pre_done` is 0 from the cycle after an accepted start with a nonzero size until the last walk request completes its handshake. The op code 4 (end) turns autoload on if `op_flag` is 1 and leaves it unchanged if `op_flag` is 0.
- R10: A walk size larger than `CAP_BYTES` is clamped to `CAP_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | AW | Configuration write data |
| line_sz | input | 2 | Line length code |
| lk_valid | input | 1 | Lookup event valid |
| lk_addr | input | AW | Lookup address |
| lk_hit | input | 1 | Lookup hit (1) or miss (0) |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation code |
| op_flag | input | 1 | Restore flag for resume and end |
| op_addr | input | AW | Walk start address |
| op_size | input | AW | Walk size in bytes |
| op_desc | input | 1 | Walk direction, 1 = descending |
| fill_valid | output | 1 | Fill request valid |
| fill_addr | output | AW | Fill request line address |
| fill_ready | input | 1 | Fill request accepted |
| auto_active | output | 1 | Autoload currently on |
| prev_auto | output | 1 | Autoload state captured by the last suspend or start |
| pre_done | output | 1 | No manual walk running |

## Verification
The hardest case to reach is a lookup that arrives while a request is stalled. It must be dropped and must not replace the held address, and this only happens when back-pressure lines up with lookups inside a window. A random phase covers it. It drives lookups scattered around both windows together with a randomly toggling `fill_ready`, under several random window, trigger, direction and line-size settings, and checks every cycle against a bench model. Directed walks cover the range ends in both directions, an unaligned start, and clamping at the capacity.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
  typedef enum logic [1:0] {
    TRG_MISS = 2'd0,
    TRG_HIT  = 2'd1,
    TRG_ANY  = 2'd2,
    TRG_OFF  = 2'd3
  } trig_e;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_SUSP   = 3'd1,
    OP_RESUME = 3'd2,
    OP_PSTART = 3'd3,
    OP_PEND   = 3'd4
  } op_e;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_BASE0 = 3'd1;
  localparam logic [2:0] SEL_SIZE0 = 3'd2;
  localparam logic [2:0] SEL_BASE1 = 3'd3;
  localparam logic [2:0] SEL_SIZE1 = 3'd4;

  typedef struct packed {
    logic       auto_on;
    logic       en1;
    logic       en0;
    logic [1:0] trig;
    logic       desc;
  } ctrl_t;
endpackage

// File: rtl/ipf_region_match.sv
module ipf_region_match #(
  parameter int AW = 24
) (
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] size,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [AW-1:0] offs;

  always_comb begin
    offs = addr - base;
    hit  = en && (addr >= base) && (offs < size);
  end
endmodule

// File: rtl/ipf_walker.sv
module ipf_walker #(
  parameter int AW        = 24,
  parameter int CAP_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] st_addr,
  input  logic [AW-1:0] st_size,
  input  logic          st_desc,
  input  logic [AW-1:0] lmask,
  input  logic [AW-1:0] lbytes,
  input  logic          adv,
  output logic          busy,
  output logic [AW-1:0] cur
);
  localparam logic [AW-1:0] CAPW = AW'(CAP_BYTES);

  logic          busy_q, busy_d;
  logic          desc_q, desc_d;
  logic [AW-1:0] cur_q, cur_d, end_q, end_d;
  logic [AW-1:0] sz_eff, lo, hi;

  always_comb begin
    sz_eff = (st_size > CAPW) ? CAPW : st_size;
    lo     = st_addr & lmask;
    hi     = (st_addr + sz_eff - AW'(1)) & lmask;
    busy_d = busy_q;
    desc_d = desc_q;
    cur_d  = cur_q;
    end_d  = end_q;
    if (start && (sz_eff != '0)) begin
      busy_d = 1'b1;
      desc_d = st_desc;
      cur_d  = st_desc ? hi : lo;
      end_d  = st_desc ? lo : hi;
    end else if (adv && busy_q) begin
      if (cur_q == end_q) busy_d = 1'b0;
      else cur_d = desc_q ? (cur_q - lbytes) : (cur_q + lbytes);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      desc_q <= 1'b0;
      cur_q  <= '0;
      end_q  <= '0;
    end else begin
      busy_q <= busy_d;
      desc_q <= desc_d;
      cur_q  <= cur_d;
      end_q  <= end_d;
    end
  end

  assign busy = busy_q;
  assign cur  = cur_q;
endmodule

// File: rtl/ipf_engine.sv
module ipf_engine
  import ipf_pkg::*;
#(
  parameter int AW        = 24,
  parameter int CAP_BYTES = 4096,
  parameter int NREG      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic [1:0]    line_sz,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  input  logic          lk_hit,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic          op_flag,
  input  logic [AW-1:0] op_addr,
  input  logic [AW-1:0] op_size,
  input  logic          op_desc,
  output logic          fill_valid,
  output logic [AW-1:0] fill_addr,
  input  logic          fill_ready,
  output logic          auto_active,
  output logic          prev_auto,
  output logic          pre_done
);
  localparam int CW = $bits(ctrl_t);

  ctrl_t         ctrl_q;
  logic [AW-1:0] base_q [NREG];
  logic [AW-1:0] size_q [NREG];
  logic [NREG-1:0] en_v, rhit;

  logic          auto_q, auto_d, prev_q, prev_d;
  logic          fv_q, fv_d, fsrc_q, fsrc_d;
  logic [AW-1:0] fa_q, fa_d;
  logic [AW-1:0] lbytes, lmask, lk_line, auto_tgt;
  logic          trig_ok, auto_fire, pstart, adv, w_busy;
  logic [AW-1:0] w_cur;

  // line length
  always_comb begin
    lbytes = (line_sz == 2'd3) ? AW'(64) : (AW'(16) << line_sz);
    lmask  = ~(lbytes - AW'(1));
  end

  assign en_v = {ctrl_q.en1, ctrl_q.en0};

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (cfg_we && cfg_sel == SEL_CTRL) begin
      ctrl_q <= ctrl_t'(cfg_wdata[CW-1:0]);
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [2:0] SB = 3'(1 + 2 * g);
    localparam logic [2:0] SS = 3'(2 + 2 * g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        size_q[g] <= '0;
      end else begin
        if (cfg_we && cfg_sel == SB) base_q[g] <= cfg_wdata;
        if (cfg_we && cfg_sel == SS) size_q[g] <= cfg_wdata;
      end
    end
    ipf_region_match #(.AW(AW)) u_match (
      .en  (en_v[g]),
      .base(base_q[g]),
      .size(size_q[g]),
      .addr(lk_addr),
      .hit (rhit[g])
    );
  end

  // autoload trigger
  always_comb begin
    unique case (ctrl_q.trig)
      TRG_MISS: trig_ok = !lk_hit;
      TRG_HIT:  trig_ok = lk_hit;
      TRG_ANY:  trig_ok = 1'b1;
      default:  trig_ok = 1'b0;
    endcase
    lk_line   = lk_addr & lmask;
    auto_tgt  = ctrl_q.desc ? (lk_line - lbytes) : (lk_line + lbytes);
    auto_fire = lk_valid && auto_q && !w_busy && trig_ok && (|rhit);
  end

  // operation decode and autoload state
  assign pstart = op_valid && (op_code == OP_PSTART) && !w_busy;

  always_comb begin
    auto_d = auto_q;
    prev_d = prev_q;
    if (cfg_we && cfg_sel == SEL_CTRL) auto_d = cfg_wdata[CW-1];
    if (op_valid) begin
      unique case (op_code)
        OP_SUSP: begin
          prev_d = auto_q;
          auto_d = 1'b0;
        end
        OP_RESUME: auto_d = op_flag;
        OP_PSTART: if (pstart) begin
          prev_d = auto_q;
          auto_d = 1'b0;
        end
        OP_PEND: if (op_flag) auto_d = 1'b1;
        default: ;
      endcase
    end
  end

  // manual walk
  assign adv = fv_q && fill_ready && fsrc_q;

  ipf_walker #(.AW(AW), .CAP_BYTES(CAP_BYTES)) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (pstart),
    .st_addr(op_addr),
    .st_size(op_size),
    .st_desc(op_desc),
    .lmask  (lmask),
    .lbytes (lbytes),
    .adv    (adv),
    .busy   (w_busy),
    .cur    (w_cur)
  );

  // single request slot
  always_comb begin
    fv_d   = fv_q;
    fa_d   = fa_q;
    fsrc_d = fsrc_q;
    if (fv_q) begin
      if (fill_ready) fv_d = 1'b0;
    end else if (w_busy) begin
      fv_d   = 1'b1;
      fa_d   = w_cur;
      fsrc_d = 1'b1;
    end else if (auto_fire) begin
      fv_d   = 1'b1;
      fa_d   = auto_tgt;
      fsrc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q <= 1'b0;
      prev_q <= 1'b0;
      fv_q   <= 1'b0;
      fa_q   <= '0;
      fsrc_q <= 1'b0;
    end else begin
      auto_q <= auto_d;
      prev_q <= prev_d;
      fv_q   <= fv_d;
      fa_q   <= fa_d;
      fsrc_q <= fsrc_d;
    end
  end

  assign fill_valid  = fv_q;
  assign fill_addr   = fa_q;
  assign auto_active = auto_q;
  assign prev_auto   = prev_q;
  assign pre_done    = !w_busy;
endmodule

// File: rtl/ipf_chk.sv
module ipf_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    line_sz,
  input logic          op_valid,
  input logic [2:0]    op_code,
  input logic          op_flag,
  input logic [AW-1:0] op_size,
  input logic          fill_valid,
  input logic [AW-1:0] fill_addr,
  input logic          fill_ready,
  input logic          auto_active,
  input logic          prev_auto,
  input logic          pre_done
);
  logic [AW-1:0] lbc;
  assign lbc = (line_sz == 2'd3) ? AW'(64) : (AW'(16) << line_sz);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !fill_ready |=> fill_valid && $stable(fill_addr));

  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && $stable(line_sz) && $stable(fill_addr) |-> (fill_addr & (lbc - AW'(1))) == '0);

  p_susp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 3'd1 |=> !auto_active && prev_auto == $past(auto_active));

  p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 3'd3 && pre_done && op_size != '0 |=> !pre_done && !auto_active);

  p_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 3'd4 && op_flag |=> auto_active);
endmodule

bind ipf_engine ipf_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_sz    (line_sz),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .op_flag    (op_flag),
  .op_size    (op_size),
  .fill_valid (fill_valid),
  .fill_addr  (fill_addr),
  .fill_ready (fill_ready),
  .auto_active(auto_active),
  .prev_auto  (prev_auto),
  .pre_done   (pre_done)
);

// File: tb/sim_ipf_engine.sv
`timescale 1ns/1ps
module sim_ipf_engine;
  localparam int AW = 24;

  logic          clk, rst_n;
  logic          cfg_we;
  logic [2:0]    cfg_sel;
  logic [AW-1:0] cfg_wdata;
  logic [1:0]    line_sz;
  logic          lk_valid, lk_hit;
  logic [AW-1:0] lk_addr;
  logic          op_valid, op_flag, op_desc;
  logic [2:0]    op_code;
  logic [AW-1:0] op_addr, op_size;
  logic          fill_valid, fill_ready, auto_active, prev_auto, pre_done;
  logic [AW-1:0] fill_addr;

  int nchk = 0, nfail = 0;
  logic [AW-1:0] got [0:127];
  int ngot;

  // bench model state for the random phase
  logic [5:0]    m_ctrl;
  logic [AW-1:0] m_b0, m_s0, m_b1, m_s1;
  logic          m_v;
  logic [AW-1:0] m_a;

  ipf_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .line_sz(line_sz), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .op_valid(op_valid), .op_code(op_code), .op_flag(op_flag), .op_addr(op_addr),
    .op_size(op_size), .op_desc(op_desc), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_ready(fill_ready), .auto_active(auto_active), .prev_auto(prev_auto),
    .pre_done(pre_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] f_lb(input logic [1:0] ls);
    return (ls == 2'd3) ? AW'(64) : (AW'(16) << ls);
  endfunction

  function automatic bit f_in(input logic en, input logic [AW-1:0] b, input logic [AW-1:0] s,
                              input logic [AW-1:0] a);
    return en && (a >= b) && (a < b + s);
  endfunction

  function automatic bit f_trig(input logic [1:0] t, input logic h);
    return (t == 2'd2) || (t == 2'd0 && !h) || (t == 2'd1 && h);
  endfunction

  function automatic logic [AW-1:0] f_tgt(input logic desc, input logic [1:0] ls, input logic [AW-1:0] a);
    logic [AW-1:0] l;
    l = a & ~(f_lb(ls) - AW'(1));
    return desc ? l - f_lb(ls) : l + f_lb(ls);
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic cfgw(input logic [2:0] sel, input logic [AW-1:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic op(input logic [2:0] c, input logic f, input logic [AW-1:0] a,
                    input logic [AW-1:0] s, input logic d);
    op_valid = 1'b1; op_code = c; op_flag = f; op_addr = a; op_size = s; op_desc = d;
    cyc();
    op_valid = 1'b0;
  endtask

  task automatic drain();
    fill_ready = 1'b1; lk_valid = 1'b0;
    cyc(); cyc();
    fill_ready = 1'b0;
  endtask

  task automatic look(input logic [AW-1:0] a, input logic h, input bit fire,
                      input logic [AW-1:0] ea, input string req);
    fill_ready = 1'b0;
    lk_valid = 1'b1; lk_addr = a; lk_hit = h;
    cyc();
    lk_valid = 1'b0;
    chk(fill_valid == fire, req, 32'(fill_valid), 32'(fire));
    if (fire) chk(fill_addr == ea, req, 32'(fill_addr), 32'(ea));
    drain();
  endtask

  task automatic walk();
    ngot = 0;
    fill_ready = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      if (fill_valid && ngot < 128) begin
        got[ngot] = fill_addr;
        ngot++;
      end
      if (pre_done && !fill_valid) break;
      cyc();
    end
    fill_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; line_sz = 0;
    lk_valid = 0; lk_addr = 0; lk_hit = 0; op_valid = 0; op_code = 0; op_flag = 0;
    op_addr = 0; op_size = 0; op_desc = 0; fill_ready = 0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    chk(!fill_valid, "R1 fill_valid", 32'(fill_valid), 0);
    chk(!auto_active, "R1 auto_active", 32'(auto_active), 0);
    chk(!prev_auto, "R1 prev_auto", 32'(prev_auto), 0);
    chk(pre_done, "R1 pre_done", 32'(pre_done), 1);

    // directed autoload, 16-byte lines
    cfgw(3'd1, 24'h1000); cfgw(3'd2, 24'h100);
    cfgw(3'd3, 24'h3000); cfgw(3'd4, 24'h80);
    cfgw(3'd0, 24'h28);                            // auto on, window 0, miss, ascending
    look(24'h1034, 1'b0, 1, 24'h1040, "R3 miss ascending");
    look(24'h1034, 1'b1, 0, 24'h0,    "R3 hit ignored in miss mode");
    look(24'h2000, 1'b0, 0, 24'h0,    "R4 outside window");
    look(24'h1100, 1'b0, 0, 24'h0,    "R4 one past window end");
    look(24'h3010, 1'b0, 0, 24'h0,    "R4 window 1 disabled");
    cfgw(3'd0, 24'h29);                            // descending
    look(24'h1034, 1'b0, 1, 24'h1020, "R3 miss descending");
    cfgw(3'd0, 24'h32);                            // window 1, hit, ascending
    look(24'h3010, 1'b1, 1, 24'h3020, "R3 hit in window 1");
    look(24'h1034, 1'b1, 0, 24'h0,    "R4 window 0 disabled");
    cfgw(3'd0, 24'h2C);                            // window 0, any
    line_sz = 2'd2;
    look(24'h1074, 1'b1, 1, 24'h1080, "R2 64-byte line");
    line_sz = 2'd1;
    look(24'h1074, 1'b0, 1, 24'h1080, "R2 32-byte line");
    line_sz = 2'd3;
    look(24'h1005, 1'b0, 1, 24'h1040, "R2 code 3 as 64");
    line_sz = 2'd0;
    cfgw(3'd0, 24'h2E);                            // trigger 3: never
    look(24'h1034, 1'b0, 0, 24'h0,    "R3 trigger off");

    // R5 stall: second lookup dropped, address held
    cfgw(3'd0, 24'h28);
    lk_valid = 1'b1; lk_addr = 24'h1010; lk_hit = 1'b0;
    cyc();
    lk_addr = 24'h1050;
    cyc();
    lk_valid = 1'b0;
    chk(fill_valid && fill_addr == 24'h1020, "R5 held under stall", 32'(fill_addr), 32'h1020);
    fill_ready = 1'b1;
    cyc();
    fill_ready = 1'b0;
    chk(!fill_valid, "R5 dropped lookup not issued", 32'(fill_valid), 0);

    // R6 suspend and resume
    op(3'd1, 1'b0, 0, 0, 0);
    chk(!auto_active && prev_auto, "R6 suspend", {30'd0, auto_active, prev_auto}, 32'h1);
    look(24'h1034, 1'b0, 0, 24'h0, "R6 suspended lookup ignored");
    op(3'd1, 1'b0, 0, 0, 0);
    chk(!prev_auto, "R6 suspend while off", 32'(prev_auto), 0);
    op(3'd2, 1'b1, 0, 0, 0);
    chk(auto_active, "R6 resume", 32'(auto_active), 1);
    look(24'h1034, 1'b0, 1, 24'h1040, "R6 resumed lookup");

    // R7 ascending walk, unaligned start
    op(3'd3, 1'b0, 24'h105, 24'h40, 1'b0);
    chk(prev_auto && !auto_active, "R7 start suspends", {30'd0, prev_auto, auto_active}, 32'h2);
    chk(!pre_done, "R9 done low during walk", 32'(pre_done), 0);
    walk();
    chk(ngot == 5, "R7 line count", 32'(ngot), 5);
    for (int i = 0; i < 5 && i < ngot; i++)
      chk(got[i] == AW'(24'h100 + 16 * i), "R7 ascending address", 32'(got[i]), 32'h100 + 16 * i);
    chk(pre_done, "R9 done after walk", 32'(pre_done), 1);
    op(3'd4, 1'b1, 0, 0, 0);
    chk(auto_active, "R9 end restores", 32'(auto_active), 1);

    // R8 descending walk
    op(3'd3, 1'b0, 24'h105, 24'h40, 1'b1);
    walk();
    chk(ngot == 5, "R8 line count", 32'(ngot), 5);
    for (int i = 0; i < 5 && i < ngot; i++)
      chk(got[i] == AW'(24'h140 - 16 * i), "R8 descending address", 32'(got[i]), 32'h140 - 16 * i);
    op(3'd4, 1'b0, 0, 0, 0);
    chk(!auto_active, "R9 end with flag 0", 32'(auto_active), 0);

    // R10 clamp at capacity (4096 bytes, 64-byte lines)
    line_sz = 2'd2;
    op(3'd3, 1'b0, 24'h0, 24'h10000, 1'b0);
    walk();
    chk(ngot == 64, "R10 clamped count", 32'(ngot), 64);
    chk(got[63] == 24'hFC0, "R10 last line", 32'(got[63]), 32'hFC0);
    line_sz = 2'd0;

    // random phase against the bench model
    for (int ep = 0; ep < 6; ep++) begin
      m_b0 = 24'h4000; m_s0 = AW'(24'h80 + ($urandom % 24'h400));
      m_b1 = 24'h6000; m_s1 = AW'(24'h80 + ($urandom % 24'h400));
      m_ctrl = {1'b1, 5'($urandom % 32)};
      line_sz = 2'($urandom % 4);
      cfgw(3'd1, m_b0); cfgw(3'd2, m_s0); cfgw(3'd3, m_b1); cfgw(3'd4, m_s1);
      cfgw(3'd0, AW'(m_ctrl));
      m_v = 1'b0; m_a = '0;
      for (int c = 0; c < 600; c++) begin
        chk(fill_valid == m_v, "R5 random valid", 32'(fill_valid), 32'(m_v));
        if (m_v) chk(fill_addr == m_a, "R3 random address", 32'(fill_addr), 32'(m_a));
        lk_valid   = ($urandom % 3) != 0;
        lk_addr    = AW'(24'h3F00 + ($urandom % 24'h2400));
        lk_hit     = 1'($urandom % 2);
        fill_ready = ($urandom % 4) == 0;
        if (m_v) begin
          if (fill_ready) m_v = 1'b0;
        end else if (lk_valid && f_trig(m_ctrl[2:1], lk_hit) &&
                     (f_in(m_ctrl[3], m_b0, m_s0, lk_addr) || f_in(m_ctrl[4], m_b1, m_s1, lk_addr))) begin
          m_v = 1'b1;
          m_a = f_tgt(m_ctrl[0], line_sz, lk_addr);
        end
        cyc();
      end
      drain();
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule